// File: doc/BRIEF.md
# Radix-4 Signed/Unsigned Integer Multiplier

This block multiplies two 32-bit integers and returns their full 64-bit product one clock later. Each operand carries its own interpretation bit, so signed-by-signed, unsigned-by-unsigned and both mixed forms all come from the same datapath. The result is always the exact product written as a 64-bit two's complement value. This is the unsigned value whenever both operands are unsigned.

The multiplier operand is split into overlapping three-bit windows that step two bit positions at a time. Each window becomes one signed digit in the range -2..+2. Each digit picks zero, the multiplicand, or twice the multiplicand, and may negate it. Negation is done by bitwise inversion plus a +1 carried into the same weight as that term. The 17 weighted terms and their carry-in bits are added into one 64-bit result, which is captured in an output register with an asynchronous active-low reset.

Top module: `radix4_mul`

## Requirements
- R1: With both mode bits at 1, the product equals the signed product of the two operands as a 64-bit two's complement value.
- R2: With both mode bits at 0, the product equals the unsigned product of the two operands.
- R3: With exactly one mode bit at 1, that operand is taken as two's complement and the other as unsigned, and the 64-bit product is exact.
- R4: The product register loads on every rising clock edge, so the result for operands held before an edge appears at the output just after it. A multiplier of 1 returns the multiplicand, sign-extended or zero-extended according to its mode bit.
- R5: While rst_n is low, the product is 0.
- R6: Digit i is formed from multiplier bits (2i+1, 2i, 2i-1), with bit -1 taken as 0. The encoding is 000/111 -> 0, 001/010 -> +1, 011 -> +2, 100 -> -2, 101/110 -> -1. A digit never selects the single and the double multiple together.
- R7: A digit is marked negative only when it also selects a nonzero multiple, so every inversion is paired with its +1.
- R8: The multiplier is widened by two bits: zeros when unsigned, copies of bit 31 when signed. This gives 17 digits. For an unsigned multiplier the top digit is never negative, and for a signed one it is always 0.
- R9: If either operand is zero, the product is zero.
- R10: The most negative value 0x80000000 and the all-ones value 0xFFFFFFFF give exact products in every mode combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the product register loads on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the product register |
| mcand | input | 32 | Multiplicand operand |
| mcand_signed | input | 1 | 1: multiplicand is two's complement; 0: unsigned |
| mplier | input | 32 | Multiplier operand; this is the operand that is recoded |
| mplier_signed | input | 1 | 1: multiplier is two's complement; 0: unsigned |
| product | output | 64 | Registered 64-bit product |

## Verification
The assertions assume that the operands and mode bits are stable across each rising edge and carry known values whenever reset is high. The identity and zero properties also assume that inputs do not change between the sample that triggers them and the edge that loads the result. The bench drives every input at the falling edge and holds it for a full cycle. The mode bits are drawn together with the operands, so all four combinations, the extreme values and the digit patterns that stress each window code are reached.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // One recoded digit: magnitude selects plus a negate flag
  typedef struct packed {
    logic neg;
    logic two;
    logic one;
  } bdig_t;

  // Three-bit window {high, mid, low} -> signed digit in -2..+2
  function automatic bdig_t enc_window(input logic [2:0] w);
    bdig_t d;
    d.one = w[1] ^ w[0];
    d.two = (w[2] & ~w[1] & ~w[0]) | (~w[2] & w[1] & w[0]);
    d.neg = w[2] & ~(w[1] & w[0]);
    return d;
  endfunction

  // Operand widening: sign copy when signed, zero otherwise
  function automatic logic ext_bit(input logic msb, input logic is_signed);
    return msb & is_signed;
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]      mplier,
  input  logic              mplier_signed,
  output logic [(N+2)/2-1:0] dig_one,
  output logic [(N+2)/2-1:0] dig_two,
  output logic [(N+2)/2-1:0] dig_neg
);
  localparam int ND = (N + 2) / 2;
  localparam int MW = 2 * ND + 1;

  logic        top_ext;
  logic [MW-1:0] mx;

  assign top_ext = ext_bit(mplier[N-1], mplier_signed);
  assign mx      = {top_ext, top_ext, mplier, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_dig
    bdig_t d;
    assign d          = enc_window(mx[2*i+2 -: 3]);
    assign dig_one[i] = d.one;
    assign dig_two[i] = d.two;
    assign dig_neg[i] = d.neg;
  end
endmodule

// File: rtl/booth_ppgen.sv
module booth_ppgen
  import booth_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0]                    mcand,
  input  logic                            mcand_signed,
  input  logic [(N+2)/2-1:0]              dig_one,
  input  logic [(N+2)/2-1:0]              dig_two,
  input  logic [(N+2)/2-1:0]              dig_neg,
  output logic [(N+2)/2-1:0][N+1:0]       pp
);
  localparam int ND = (N + 2) / 2;
  localparam int XW = N + 2;

  logic          xe;
  logic [XW-1:0] x1;
  logic [XW-1:0] x2;

  assign xe = ext_bit(mcand[N-1], mcand_signed);
  assign x1 = {xe, xe, mcand};
  assign x2 = {xe, mcand, 1'b0};

  for (genvar i = 0; i < ND; i++) begin : g_pp
    logic [XW-1:0] mag;
    always_comb begin
      if (dig_two[i])      mag = x2;
      else if (dig_one[i]) mag = x1;
      else                 mag = '0;
    end
    assign pp[i] = dig_neg[i] ? ~mag : mag;
  end
endmodule

// File: rtl/booth_accum.sv
module booth_accum #(
  parameter int N = 32
) (
  input  logic [(N+2)/2-1:0][N+1:0] pp,
  input  logic [(N+2)/2-1:0]        dig_neg,
  output logic [2*N-1:0]            sum
);
  localparam int ND = (N + 2) / 2;
  localparam int XW = N + 2;
  localparam int PW = 2 * N;

  function automatic logic [PW-1:0] widen(input logic [XW-1:0] v);
    return {{(PW-XW){v[XW-1]}}, v};
  endfunction

  always_comb begin
    sum = '0;
    for (int i = 0; i < ND; i++) begin
      sum = sum + (widen(pp[i]) << (2 * i));
      sum = sum + ({{(PW-1){1'b0}}, dig_neg[i]} << (2 * i));
    end
  end
endmodule

// File: rtl/radix4_mul.sv
module radix4_mul #(
  parameter int N = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   mcand,
  input  logic           mcand_signed,
  input  logic [N-1:0]   mplier,
  input  logic           mplier_signed,
  output logic [2*N-1:0] product
);
  localparam int ND = (N + 2) / 2;
  localparam int XW = N + 2;

  logic [ND-1:0]          dig_one;
  logic [ND-1:0]          dig_two;
  logic [ND-1:0]          dig_neg;
  logic [ND-1:0][XW-1:0]  pp;
  logic [2*N-1:0]         sum_c;

  booth_recode #(.N(N)) u_rec (
    .mplier        (mplier),
    .mplier_signed (mplier_signed),
    .dig_one       (dig_one),
    .dig_two       (dig_two),
    .dig_neg       (dig_neg)
  );

  booth_ppgen #(.N(N)) u_pp (
    .mcand        (mcand),
    .mcand_signed (mcand_signed),
    .dig_one      (dig_one),
    .dig_two      (dig_two),
    .dig_neg      (dig_neg),
    .pp           (pp)
  );

  booth_accum #(.N(N)) u_acc (
    .pp      (pp),
    .dig_neg (dig_neg),
    .sum     (sum_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) product <= '0;
    else        product <= sum_c;
  end
endmodule

// File: rtl/radix4_mul_chk.sv
module radix4_mul_chk #(
  parameter int N  = 32,
  parameter int ND = 17
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N-1:0]   mcand,
  input logic           mcand_signed,
  input logic [N-1:0]   mplier,
  input logic           mplier_signed,
  input logic [2*N-1:0] product,
  input logic [ND-1:0]  dig_one,
  input logic [ND-1:0]  dig_two,
  input logic [ND-1:0]  dig_neg
);
  logic [2*N-1:0] mcand_wide;
  assign mcand_wide = (mcand_signed && mcand[N-1]) ? {{N{1'b1}}, mcand}
                                                   : {{N{1'b0}}, mcand};

  for (genvar i = 0; i < ND; i++) begin : g_d
    AST_DIGIT_SINGLE_MAG: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dig_one[i], dig_two[i]})); // R6
    AST_NEG_HAS_MAG: assert property (@(posedge clk) disable iff (!rst_n)
      dig_neg[i] |-> (dig_one[i] || dig_two[i])); // R7
  end

  AST_TOP_UNSIGNED_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    !mplier_signed |-> !dig_neg[ND-1]); // R8
  AST_TOP_SIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mplier_signed |-> !(dig_one[ND-1] || dig_two[ND-1] || dig_neg[ND-1])); // R8
  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (mcand == '0 || mplier == '0) |=> (product == '0)); // R9
  AST_UNIT_MULTIPLIER: assert property (@(posedge clk) disable iff (!rst_n)
    (mplier == {{(N-1){1'b0}}, 1'b1}) |=> (product == $past(mcand_wide))); // R4
endmodule

bind radix4_mul radix4_mul_chk #(.N(N), .ND(ND)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mcand         (mcand),
  .mcand_signed  (mcand_signed),
  .mplier        (mplier),
  .mplier_signed (mplier_signed),
  .product       (product),
  .dig_one       (dig_one),
  .dig_two       (dig_two),
  .dig_neg       (dig_neg)
);

// File: tb/radix4_mul_tb.sv
module radix4_mul_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mcand = '0;
  logic        mcand_signed = 1'b0;
  logic [31:0] mplier = '0;
  logic        mplier_signed = 1'b0;
  logic [63:0] product;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  radix4_mul u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .mcand         (mcand),
    .mcand_signed  (mcand_signed),
    .mplier        (mplier),
    .mplier_signed (mplier_signed),
    .product       (product)
  );

  // Behavioural reference: widen each operand, multiply, keep 64 bits
  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic sa,
                                          input logic [31:0] b, input logic sb);
    logic [63:0] wa, wb;
    wa = sa ? 64'(signed'(a)) : 64'(a);
    wb = sb ? 64'(signed'(b)) : 64'(b);
    return wa * wb;
  endfunction

  function automatic string mode_tag(input logic sa, input logic sb);
    if (sa && sb)   return "R1";
    if (!sa && !sb) return "R2";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: product=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] a, input logic sa,
                     input logic [31:0] b, input logic sb);
    @(negedge clk);
    mcand = a; mcand_signed = sa; mplier = b; mplier_signed = sb;
    @(negedge clk);
    check(tag, product, ref_mul(a, sa, b, sb));
  endtask

  initial begin
    logic [31:0] edge_v [6];
    edge_v[0] = 32'h8000_0000; edge_v[1] = 32'hFFFF_FFFF; edge_v[2] = 32'h7FFF_FFFF;
    edge_v[3] = 32'h0000_0001; edge_v[4] = 32'h0000_0000; edge_v[5] = 32'h0000_0002;
    void'($urandom(32'd2024));

    // R5: reset holds product at zero even with operands applied
    mcand = 32'h1234_5678; mplier = 32'h9ABC_DEF0;
    repeat (2) @(negedge clk);
    check("R5 reset", product, 64'h0);
    rst_n = 1'b1;

    // R4: one-cycle latency and unit multiplier
    run("R4 unit signed", 32'hFFFF_FFF3, 1'b1, 32'h1, 1'b0);
    run("R4 unit unsigned", 32'hFFFF_FFF3, 1'b0, 32'h1, 1'b1);

    // R1/R2/R3 small directed
    run("R1 -13*-7", 32'hFFFF_FFF3, 1'b1, 32'hFFFF_FFF9, 1'b1);
    run("R2 13*7", 32'd13, 1'b0, 32'd7, 1'b0);
    run("R3 +13*-7", 32'd13, 1'b0, 32'hFFFF_FFF9, 1'b1);
    run("R3 -13*u", 32'hFFFF_FFF3, 1'b1, 32'd7, 1'b0);

    // R6: window patterns covering every three-bit code
    run("R6 alt 01", 32'h0000_ABCD, 1'b1, 32'h5555_5555, 1'b0);
    run("R6 alt 10", 32'h0000_ABCD, 1'b1, 32'hAAAA_AAAA, 1'b1);
    run("R6 runs", 32'h8765_4321, 1'b0, 32'h3C3C_C3C3, 1'b0);
    run("R6 mixed", 32'hDEAD_BEEF, 1'b1, 32'h6D9B_2E71, 1'b1);

    // R7: many negative digits at once
    run("R7 neg digits", 32'h0F0F_0F0F, 1'b1, 32'hEEEE_EEEE, 1'b1);
    run("R7 neg digits u", 32'hF0F0_F0F0, 1'b0, 32'hDDDD_DDDD, 1'b0);

    // R8: top-bit set multiplier in both modes
    run("R8 unsigned top", 32'h0000_0003, 1'b0, 32'h8000_0000, 1'b0);
    run("R8 signed top", 32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1);
    run("R8 unsigned top2", 32'hFFFF_FFFF, 1'b1, 32'hC000_0001, 1'b0);

    // R9: zero operand
    run("R9 zero mcand", 32'h0, 1'b1, 32'hFFFF_FFFF, 1'b1);
    run("R9 zero mplier", 32'h8000_0000, 1'b1, 32'h0, 1'b0);

    // R10: extremes in all four mode combinations
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int m = 0; m < 4; m++)
          run("R10 extremes", edge_v[i], m[0], edge_v[j], m[1]);

    // Random, tagged by mode combination
    for (int k = 0; k < 800; k++) begin
      logic [31:0] a, b;
      logic sa, sb;
      a = $urandom(); b = $urandom();
      sa = $urandom_range(0, 1) == 1;
      sb = $urandom_range(0, 1) == 1;
      run(mode_tag(sa, sb), a, sa, b, sb);
    end

    // R5 again: asynchronous reset clears a nonzero product
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    check("R5 async clear", product, 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: product=%h expected=completion", product);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule